// File: doc/BRIEF.md
# Serial Register Access Slave with Command Parity

This block lets an external host read and write a bank of 8-bit registers over a four-wire serial link. Every access is one fixed frame of 16 serial clock cycles. The first byte from the host is a command byte and the second byte is data. While the command byte arrives, the slave returns a system status byte. While the data byte arrives, it returns the addressed register's contents. The register bank sits outside the block and is reached through a parallel port: an address, write data, a single-cycle write strobe, and read data that the bank supplies for the presented address.

The serial inputs are brought into the system clock domain through two-flop synchronizers. The system clock must run at least four times faster than the serial clock. The serial clock idles low. The slave changes MISO after each rising edge and takes MOSI on each falling edge. A write is applied only when slave select rises at the end of the frame. It is applied only if the frame held exactly 16 falling edges and the command parity is correct. A rejected frame raises a one-cycle error pulse.

Top module: `spi_reg_slave`

## Requirements
- R1: Command byte layout: bit 7 is the access flag (1 = read, 0 = write), bits 6..2 are the register address (MSB first on the wire), bit 1 is parity and bit 0 is ignored. A read frame never asserts `reg_we`.
- R2: The parity bit is correct when it equals the XOR of the access flag and the five address bits. A write whose parity bit is wrong leaves the bank unwritten and pulses `frame_error`.
- R3: A read is served whatever its parity bit holds. It returns register data, and `frame_error` stays low when the frame length is correct.
- R4: During the first byte, MISO carries the `status_in` value latched when slave select falls, bit 7 first. The first bit is available before the first rising serial clock edge.
- R5: During the second byte, MISO carries the addressed register's value, bit 7 first. The value is captured on the 7th falling edge, when the parity bit is taken in. For a write, this is the value the register held before the write.
- R6: A frame is valid only if exactly 16 falling serial clock edges occur while slave select is low. A frame with fewer or more edges causes no write and pulses `frame_error` once.
- R7: A valid write is committed after slave select rises, never earlier. The commit is a single-cycle `reg_we` pulse, with `reg_addr` set to the command address and `reg_wdata` set to the second byte.
- R8: `miso_oe` is low while slave select is high, including after reset, and high while slave select is low.
- R9: `frame_error` is a single-cycle pulse that never coincides with `reg_we`. It never occurs for a valid frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| ss_n | input | 1 | Slave select, active low |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the MISO tri-state driver |
| status_in | input | 8 | Status byte returned during the command byte |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_addr | output | 5 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register contents at `reg_addr` |
| frame_error | output | 1 | One-cycle pulse for a rejected frame |

## Verification
The hardest conditions to reach are frames that are wrong in only one respect. Examples are a write one edge short or one edge long, and a write that is complete but carries a flipped parity bit. The host model in the bench therefore takes an edge count and a parity-corruption flag as arguments, so a well-formed command can be sent with exactly one defect. After each rejected frame, a clean read frame fetches the targeted register. This shows at the ports that the bank was not touched. A write to a register with a known old value confirms that the second returned byte is the pre-write contents.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
  localparam int FRAME_BITS = 16;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 5;
  // Positions inside the 16-bit received frame (first bit lands in MSB)
  localparam int POS_RW     = FRAME_BITS - 1;
  localparam int POS_ADDR_H = POS_RW - 1;
  localparam int POS_ADDR_L = POS_RW - ADDR_W;
  localparam int POS_PAR    = POS_ADDR_L - 1;
  // Falling-edge index (1-based) after which the address is complete
  localparam int EDGE_ADDR  = 1 + ADDR_W;
  // Falling-edge index at which the parity bit arrives: read data captured
  localparam int EDGE_CAP   = EDGE_ADDR + 1;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
      end else begin
        s1 <= din[i];
        s2 <= s1;
      end
    end
    assign dout[i] = s2;
  end
endmodule

// File: rtl/spi_rx_frame.sv
module spi_rx_frame
  import spi_reg_pkg::*;
#(
  parameter int FBITS = FRAME_BITS,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          ss_fall,
  input  logic          ss_rise,
  input  logic          sclk_fall,
  input  logic          mosi_s,
  input  logic [DW-1:0] reg_rdata,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] rd_cap,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  output logic          frame_error
);
  localparam int CNT_W = $clog2(FBITS + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FBITS);
  localparam logic [CNT_W-1:0] CNT_ADR  = CNT_W'(EDGE_ADDR - 1);
  localparam logic [CNT_W-1:0] CNT_CAP  = CNT_W'(EDGE_CAP - 1);

  logic [CNT_W-1:0] fcnt;
  logic [FBITS-1:0] sr;
  logic             len_ok, is_wr, par_ok;

  assign len_ok = (fcnt == CNT_FULL);
  assign is_wr  = ~sr[POS_RW];
  assign par_ok = (sr[POS_PAR] == ^sr[POS_RW:POS_ADDR_L]);

  // Shift in MOSI on falling edges, track edge count, address and read capture
  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt     <= '0;
      sr       <= '0;
      reg_addr <= '0;
      rd_cap   <= '0;
    end else if (ss_fall) begin
      fcnt <= '0;
    end else if (active && sclk_fall) begin
      sr <= {sr[FBITS-2:0], mosi_s};
      if (fcnt != CNT_MAX) fcnt <= fcnt + 1'b1;
      if (fcnt == CNT_ADR) reg_addr <= {sr[AW-2:0], mosi_s};
      if (fcnt == CNT_CAP) rd_cap <= reg_rdata;
    end
  end

  // Commit or reject on the rising edge of slave select
  always_ff @(posedge clk) begin
    if (rst) begin
      reg_we      <= 1'b0;
      reg_wdata   <= '0;
      frame_error <= 1'b0;
    end else begin
      reg_we      <= 1'b0;
      frame_error <= 1'b0;
      if (ss_rise) begin
        if (len_ok && is_wr && par_ok) begin
          reg_we    <= 1'b1;
          reg_wdata <= sr[DW-1:0];
        end else if (!len_ok || (is_wr && !par_ok)) begin
          frame_error <= 1'b1;
        end
      end
    end
  end

  assert_we_single_R7: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  assert_we_addr_stable_R7: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $stable(reg_addr));
  assert_we_not_error_R9: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !frame_error);
  assert_err_single_R9: assert property (@(posedge clk) disable iff (rst)
    frame_error |=> !frame_error);
endmodule

// File: rtl/spi_tx.sv
module spi_tx
  import spi_reg_pkg::*;
#(
  parameter int FBITS = FRAME_BITS,
  parameter int DW    = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          active,
  input  logic          ss_fall,
  input  logic          sclk_rise,
  input  logic [DW-1:0] status_in,
  input  logic [DW-1:0] rd_cap,
  output logic          miso,
  output logic          miso_oe
);
  localparam int CNT_W = $clog2(FBITS + 2) + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] rc;
  logic [DW-1:0]    st_lat;
  logic             nxt_bit;

  // Bit to present for the rc-th rising edge: status first, then read data
  always_comb begin
    int idx;
    idx = int'(rc);
    nxt_bit = 1'b0;
    if (idx < DW)            nxt_bit = st_lat[DW-1-idx];
    else if (idx < 2 * DW)   nxt_bit = rd_cap[2*DW-1-idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rc      <= '0;
      st_lat  <= '0;
      miso    <= 1'b0;
      miso_oe <= 1'b0;
    end else begin
      miso_oe <= active;
      if (ss_fall) begin
        rc     <= '0;
        st_lat <= status_in;
        miso   <= status_in[DW-1];
      end else if (active && sclk_rise) begin
        miso <= nxt_bit;
        if (rc != CNT_MAX) rc <= rc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int FBITS = FRAME_BITS,
  parameter int DW    = DATA_W,
  parameter int AW    = ADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ss_n,
  input  logic          sclk,
  input  logic          mosi,
  output logic          miso,
  output logic          miso_oe,
  input  logic [DW-1:0] status_in,
  output logic          reg_we,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata,
  output logic          frame_error
);
  logic [2:0] s_vec;
  logic       ss_s, sclk_s, mosi_s;
  logic       ss_q, sclk_q;
  logic       ss_fall, ss_rise, sclk_fall, sclk_rise, active;
  logic [DW-1:0] rd_cap;

  spi_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst(rst), .din({mosi, sclk, ss_n}), .dout(s_vec)
  );
  assign ss_s   = s_vec[0];
  assign sclk_s = s_vec[1];
  assign mosi_s = s_vec[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      ss_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      ss_q   <= ss_s;
      sclk_q <= sclk_s;
    end
  end

  assign active    = ~ss_s;
  assign ss_fall   = ss_q & ~ss_s;
  assign ss_rise   = ~ss_q & ss_s;
  assign sclk_fall = sclk_q & ~sclk_s;
  assign sclk_rise = ~sclk_q & sclk_s;

  spi_rx_frame #(.FBITS(FBITS), .DW(DW), .AW(AW)) u_rx (
    .clk(clk), .rst(rst), .active(active), .ss_fall(ss_fall),
    .ss_rise(ss_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .reg_rdata(reg_rdata), .reg_addr(reg_addr), .rd_cap(rd_cap),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .frame_error(frame_error)
  );

  spi_tx #(.FBITS(FBITS), .DW(DW)) u_tx (
    .clk(clk), .rst(rst), .active(active), .ss_fall(ss_fall),
    .sclk_rise(sclk_rise), .status_in(status_in), .rd_cap(rd_cap),
    .miso(miso), .miso_oe(miso_oe)
  );

  assert_err_oe_off_R8: assert property (@(posedge clk) disable iff (rst)
    frame_error |-> !miso_oe);
  assert_we_oe_off_R8: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> !miso_oe);
endmodule

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ss_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic       miso, miso_oe, reg_we, frame_error;
  logic [7:0] status_in = 8'h00;
  logic [4:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  int errs = 0, checks = 0;
  logic [7:0] bank  [32];
  logic [7:0] model [32];
  int we_cnt = 0, err_cnt = 0;
  logic [4:0] we_addr;
  logic [7:0] we_data;
  int ss_stable = 0;
  logic ss_last = 1'b1;

  always #4 clk = ~clk;

  spi_reg_slave dut (
    .clk(clk), .rst(rst), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .status_in(status_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .frame_error(frame_error)
  );

  assign reg_rdata = bank[reg_addr];
  always @(posedge clk) if (reg_we) bank[reg_addr] <= reg_wdata;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the behavioural model
  always @(negedge clk) begin
    if (!rst) begin
      if (ss_n == ss_last) ss_stable++; else ss_stable = 0;
      ss_last = ss_n;
      if (ss_stable >= 4) chk(miso_oe == !ss_n, "R8 miso_oe", miso_oe, !ss_n);
      if (reg_we || frame_error) chk(!(reg_we && frame_error), "R9 we/err overlap", 1, 0);
      if (reg_we) begin
        chk(ss_n == 1'b1, "R7 commit only after ss rise", ss_n, 1);
        we_cnt++; we_addr = reg_addr; we_data = reg_wdata;
      end
      if (frame_error) err_cnt++;
    end
  end

  function automatic logic [7:0] mkcmd(input bit rd, input logic [4:0] a, input bit badpar);
    return {rd, a, (^{rd, a}) ^ badpar, 1'b0};
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic frame(input logic [7:0] cmd, input logic [7:0] dat, input int nedges,
                       output logic [15:0] got);
    logic [15:0] tx;
    tx = {cmd, dat};
    got = '0;
    we_cnt = 0; err_cnt = 0;
    wclk(1); ss_n = 1'b0;
    wclk(8);
    for (int i = 0; i < nedges; i++) begin
      sclk = 1'b1; mosi = (i < 16) ? tx[15-i] : 1'b0;
      wclk(8);
      if (i < 16) got[15-i] = miso;
      sclk = 1'b0;
      wclk(8);
    end
    ss_n = 1'b1;
    wclk(12);
  endtask

  task automatic do_read(input logic [4:0] a, input logic [7:0] st, input string tag);
    logic [15:0] g;
    status_in = st;
    frame(mkcmd(1'b1, a, 1'b0), 8'h00, 16, g);
    chk(g[15:8] == st, {tag, " R4 status"}, g[15:8], st);
    chk(g[7:0] == model[a], {tag, " R5 readback"}, g[7:0], model[a]);
    chk(we_cnt == 0, {tag, " R1 read no write"}, we_cnt, 0);
    chk(err_cnt == 0, {tag, " R9 no error"}, err_cnt, 0);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [7:0] d, input logic [7:0] st);
    logic [15:0] g;
    status_in = st;
    frame(mkcmd(1'b0, a, 1'b0), d, 16, g);
    chk(g[15:8] == st, "R4 status in write", g[15:8], st);
    chk(g[7:0] == model[a], "R5 old value in write", g[7:0], model[a]);
    chk(we_cnt == 1, "R7 one strobe", we_cnt, 1);
    chk(we_addr == a, "R7 write addr", we_addr, a);
    chk(we_data == d, "R7 write data", we_data, d);
    chk(err_cnt == 0, "R9 no error on good write", err_cnt, 0);
    model[a] = d;
  endtask

  task automatic bad_write(input logic [4:0] a, input logic [7:0] d, input bit badpar,
                           input int n, input string tag);
    logic [15:0] g;
    frame(mkcmd(1'b0, a, badpar), d, n, g);
    chk(we_cnt == 0, {tag, " no write"}, we_cnt, 0);
    chk(err_cnt == 1, {tag, " one error pulse"}, err_cnt, 1);
    do_read(a, 8'h5C, {tag, " bank unchanged"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [15:0] g;
    for (int i = 0; i < 32; i++) begin
      bank[i] = 8'(i * 7 + 3);
      model[i] = 8'(i * 7 + 3);
    end
    wclk(5);
    rst = 1'b0;
    wclk(1);
    chk(miso_oe == 1'b0, "R8 reset oe", miso_oe, 0);
    chk(reg_we == 1'b0, "R7 reset we", reg_we, 0);
    chk(frame_error == 1'b0, "R9 reset err", frame_error, 0);
    wclk(6);

    do_read(5'd3, 8'hA5, "R1 read reg3");
    do_write(5'd5, 8'h3C, 8'h96);
    do_read(5'd5, 8'h96, "R7 readback reg5");
    do_write(5'd31, 8'hFF, 8'h01);
    do_write(5'd0, 8'h00, 8'h80);
    do_read(5'd31, 8'hFF, "R1 read reg31");
    do_read(5'd0, 8'h00, "R1 read reg0");

    // R2: write with flipped parity
    bad_write(5'd9, 8'hE1, 1'b1, 16, "R2 bad parity");
    // R3: read with flipped parity is still served
    status_in = 8'h6B;
    frame(mkcmd(1'b1, 5'd9, 1'b1), 8'h00, 16, g);
    chk(g[7:0] == model[9], "R3 read ignores parity", g[7:0], model[9]);
    chk(err_cnt == 0, "R3 no error", err_cnt, 0);
    chk(g[15:8] == 8'h6B, "R4 status bad-parity read", g[15:8], 8'h6B);

    // R6: edge count faults
    bad_write(5'd12, 8'h77, 1'b0, 15, "R6 15 edges");
    bad_write(5'd12, 8'h77, 1'b0, 17, "R6 17 edges");
    bad_write(5'd13, 8'h11, 1'b0, 0, "R6 0 edges");
    frame(mkcmd(1'b1, 5'd4, 1'b0), 8'h00, 12, g);
    chk(err_cnt == 1, "R6 short read error", err_cnt, 1);
    chk(we_cnt == 0, "R6 short read no write", we_cnt, 0);

    // Sweep of writes with back-to-back readback
    for (int k = 0; k < 6; k++) begin
      do_write(5'(k * 5 + 2), 8'(8'hC3 ^ (k * 37)), 8'(k * 41));
      do_read(5'(k * 5 + 2), 8'(~(k * 19)), "R5 sweep readback");
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule